// File: doc/BRIEF.md
# Divider Configuration Loader (serial and parallel)

This block holds the configuration word of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. The value can arrive in two ways. In parallel mode, dedicated pins drive the divide values. In serial mode, a 14-bit shift register is filled one bit at a time and then committed. A flag shows whether the active feedback value lies inside the window where the loop can lock.

All control inputs are levels that are already synchronous to `clk`. The block samples each control input once per clock and finds its edges by comparing it with the value from the previous cycle. A serial load passes through two register stages. The rising edge of the serial strobe fills a staging register. While the strobe stays high, the staging register follows every new shift. The falling edge copies the staging register into the active registers. The serial side is a plain clocked bit interface with no valid/ready handshake, because the source supplies a bit clock rather than a stream. There is therefore no back-pressure: a bit is taken on every sampled rising edge of the bit clock.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst` is high, the block synchronously sets `m_div` to 125, `n_div` to 0 and `t_sel` to 0. It also clears the shift register, so `ser_dout` reads 0 and `m_lock_ok` reads 1.
- R2: While `par_ld_n` is low, each clock copies `par_m` and `par_n` into `m_div` and `n_div`, visible one clock later. `t_sel` reads 000 from one clock after `par_ld_n` goes low.
- R3: Once `par_ld_n` is high, `m_div` and `n_div` hold the pin values from the last cycle in which `par_ld_n` was low. They keep holding until `par_ld_n` goes low again or a serial commit occurs, whatever the pins do.
- R4: On every cycle where `ser_sck` is high and was low in the previous cycle, `ser_din` is shifted into bit 0 of the 14-bit shift register, in either mode. `ser_dout` is bit 13 of that register.
- R5: The serial frame is sent most-significant bit first. The order is test bits 2..0, then output divide bits 1..0, then feedback bits 8..0, so feedback bit 0 is the last bit sent. In the shift register, bits 13:11 hold the test code, bits 10:9 the output divide and bits 8:0 the feedback value.
- R6: A rising edge of `ser_ld` while `par_ld_n` is high copies the shift register into the staging register. The active outputs do not change on that edge.
- R7: A falling edge of `ser_ld` while `par_ld_n` is high copies the staging register into `m_div`, `n_div` and `t_sel`. The new values are visible one clock later.
- R8: While `ser_ld` stays high with `par_ld_n` high, every shift updates the staging register with the new shift-register contents. A later falling edge therefore commits the bits shifted last.
- R9: `m_lock_ok` is 1 exactly when 125 <= `m_div` <= 350.
- R10: Edges of `ser_ld` that occur while `par_ld_n` is low change neither the staging nor the active registers. When `par_ld_n` returns high, `t_sel` shows the test code from the last serial commit.
- R11: A serial commit overwrites values latched from the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_ld_n | input | 1 | Low selects parallel mode |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_ld | input | 1 | Serial load strobe |
| ser_sck | input | 1 | Serial bit clock (sampled level) |
| ser_din | input | 1 | Serial data bit |
| m_div | output | 9 | Active feedback divide value |
| n_div | output | 2 | Active output divide code |
| t_sel | output | 3 | Effective test-select code |
| m_lock_ok | output | 1 | Active feedback value lies in the lock window |
| ser_dout | output | 1 | Shift register bit 13 |

## Verification
The bench builds the block with its default parameters: a 9-bit feedback field, a 2-bit output field, a 3-bit test field and a lock window of 125 to 350. At this size all 512 feedback codes can be swept through the parallel path, with the lock flag checked against the window for each code. Serial frames cover a spread of codes that includes 124, 125, 350 and 351, together with every test code. Directed sequences cover the transparent staging path and strobes issued during parallel mode.

// File: rtl/divcfg_pkg.sv
`timescale 1ns/1ps
package divcfg_pkg;

  typedef enum logic [1:0] {
    LD_PAR      = 2'd0,
    LD_SER_HOLD = 2'd1,
    LD_SER_PASS = 2'd2
  } ld_mode_e;

  function automatic logic in_window(input int value, input int lo, input int hi);
    return (value >= lo) && (value <= hi);
  endfunction

endpackage

// File: rtl/divcfg_sampler.sv
`timescale 1ns/1ps
module divcfg_sampler #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_VAL;
    else     lvl_q <= sig;
  end
endmodule

// File: rtl/divcfg_shift.sv
`timescale 1ns/1ps
module divcfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q_next,
  output logic         msb
);
  logic [W-1:0] sr_q;

  assign q_next = en ? {sr_q[W-2:0], din} : sr_q;
  assign msb    = sr_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= q_next;
  end

  AST_SHIFT_IN:   assert property (@(posedge clk) disable iff (rst) en |=> (sr_q[0] == $past(din)));  // R4
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(sr_q));           // R4
endmodule

// File: rtl/divcfg_hold.sv
`timescale 1ns/1ps
module divcfg_hold #(
  parameter int          W       = 14,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/divcfg_loader.sv
`timescale 1ns/1ps
module divcfg_loader #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 3,
  parameter int M_RST = 125,
  parameter int M_LO  = 125,
  parameter int M_HI  = 350
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_ld,
  input  logic           ser_sck,
  input  logic           ser_din,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_div,
  output logic [T_W-1:0] t_sel,
  output logic           m_lock_ok,
  output logic           ser_dout
);
  import divcfg_pkg::*;

  localparam int FW = T_W + N_W + M_W;
  localparam int N_LO = M_W;
  localparam int T_LO = M_W + N_W;
  localparam logic [FW-1:0] FRAME_RST = {T_W'(0), N_W'(0), M_W'(M_RST)};

  // sampled levels: [2]=parallel strobe, [1]=serial strobe, [0]=bit clock
  logic [2:0] lvl_q;
  divcfg_sampler #(.W(3), .RST_VAL(3'b100)) u_smp (
    .clk(clk), .rst(rst), .sig({par_ld_n, ser_ld, ser_sck}), .lvl_q(lvl_q)
  );

  logic par_q, ser_q, sck_q;
  assign par_q = lvl_q[2];
  assign ser_q = lvl_q[1];
  assign sck_q = lvl_q[0];

  logic sck_rise, ser_rise, ser_fall;
  assign sck_rise = ser_sck & ~sck_q;
  assign ser_rise = ser_ld & ~ser_q;
  assign ser_fall = ~ser_ld & ser_q;

  ld_mode_e mode;
  always_comb begin
    if (!par_ld_n)  mode = LD_PAR;
    else if (ser_ld) mode = LD_SER_PASS;
    else             mode = LD_SER_HOLD;
  end

  logic [FW-1:0] sr_next;
  divcfg_shift #(.W(FW)) u_shift (
    .clk(clk), .rst(rst), .en(sck_rise), .din(ser_din),
    .q_next(sr_next), .msb(ser_dout)
  );

  logic          stage_ld;
  logic [FW-1:0] stage_q;
  assign stage_ld = (mode == LD_SER_PASS) && (ser_rise || sck_rise);

  divcfg_hold #(.W(FW), .RST_VAL(FRAME_RST)) u_stage (
    .clk(clk), .rst(rst), .ld(stage_ld), .d(sr_next), .q(stage_q)
  );

  logic          act_ld;
  logic [FW-1:0] act_d, act_q;
  always_comb begin
    act_ld = 1'b0;
    act_d  = stage_q;
    unique case (mode)
      LD_PAR: begin
        act_ld = 1'b1;
        act_d  = {act_q[FW-1:T_LO], par_n, par_m};
      end
      LD_SER_HOLD: act_ld = ser_fall;
      default:     act_ld = 1'b0;
    endcase
  end

  divcfg_hold #(.W(FW), .RST_VAL(FRAME_RST)) u_active (
    .clk(clk), .rst(rst), .ld(act_ld), .d(act_d), .q(act_q)
  );

  assign m_div     = act_q[M_W-1:0];
  assign n_div     = act_q[T_LO-1:N_LO];
  assign t_sel     = par_q ? act_q[FW-1:T_LO] : '0;
  assign m_lock_ok = in_window(int'(m_div), M_LO, M_HI);

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !par_ld_n |=> (m_div == $past(par_m) && n_div == $past(par_n)));                       // R2
  AST_TEST_ZERO:  assert property (@(posedge clk) disable iff (rst)
    !par_ld_n |=> (t_sel == '0));                                                            // R2
  AST_HOLD_DIV:   assert property (@(posedge clk) disable iff (rst)
    (par_ld_n && !ser_fall) |=> (m_div == $past(m_div) && n_div == $past(n_div)));          // R3
  AST_SER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (par_ld_n && ser_fall) |=> ({t_sel, n_div, m_div} == $past(stage_q)));                  // R7
endmodule

// File: tb/divcfg_loader_test.sv
`timescale 1ns/1ps
module divcfg_loader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_ld_n = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_ld = 1'b0;
  logic       ser_sck = 1'b0;
  logic       ser_din = 1'b0;
  logic [8:0] m_div;
  logic [1:0] n_div;
  logic [2:0] t_sel;
  logic       m_lock_ok;
  logic       ser_dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  divcfg_loader uut (
    .clk(clk), .rst(rst), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
    .ser_ld(ser_ld), .ser_sck(ser_sck), .ser_din(ser_din),
    .m_div(m_div), .n_div(n_div), .t_sel(t_sel), .m_lock_ok(m_lock_ok), .ser_dout(ser_dout)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit lock_exp(input int m);
    return (m >= 125) && (m <= 350);
  endfunction

  task automatic send_bit(input logic b);
    ser_din = b;
    ser_sck = 1'b1;
    tick();
    ser_sck = 1'b0;
    tick();
  endtask

  task automatic send_frame(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic chk_active(input string req, input int t, input int n, input int m);
    chk(m_div == 9'(m), req, int'(m_div), m);
    chk(n_div == 2'(n), req, int'(n_div), n);
    chk(t_sel == 3'(t), req, int'(t_sel), t);
  endtask

  initial begin
    int pm;
    int mv;
    tick(); tick(); tick();
    // R1 reset values
    chk_active("R1", 0, 0, 125);
    chk(ser_dout == 1'b0, "R1", int'(ser_dout), 0);
    chk(m_lock_ok == 1'b1, "R1", int'(m_lock_ok), 1);
    rst = 1'b0;
    tick();

    // R2 / R9 parallel sweep of every feedback code
    par_ld_n = 1'b0;
    for (int m = 0; m < 512; m++) begin
      par_m = 9'(m);
      par_n = 2'(m % 4);
      tick();
      chk_active("R2", 0, m % 4, m);
      chk(m_lock_ok == lock_exp(m), "R9", int'(m_lock_ok), int'(lock_exp(m)));
    end

    // R3 latch on leaving parallel mode
    par_m = 9'd200; par_n = 2'd2;
    tick();
    par_ld_n = 1'b1; par_m = 9'd17; par_n = 2'd1;
    tick();
    for (int i = 0; i < 5; i++) begin
      par_m = 9'(i * 97 + 3); par_n = 2'(i);
      tick();
      chk_active("R3", 0, 2, 200);
    end

    // R4 R5 R6 R7 R9 serial frames
    pm = 200;
    for (int k = 0; k < 22; k++) begin
      case (k)
        0: mv = 124;
        1: mv = 125;
        2: mv = 350;
        3: mv = 351;
        default: mv = (k - 4) * 29;
      endcase
      send_frame(3'(k % 8), 2'((k + 1) % 4), 9'(mv));
      chk(ser_dout == 1'((k % 8) >> 2), "R4", int'(ser_dout), (k % 8) >> 2);
      ser_ld = 1'b1;
      tick();
      chk(m_div == 9'(pm), "R6", int'(m_div), pm);
      ser_ld = 1'b0;
      tick();
      chk_active("R5 R7", k % 8, (k + 1) % 4, mv);
      chk(m_lock_ok == lock_exp(mv), "R9", int'(m_lock_ok), int'(lock_exp(mv)));
      pm = mv;
    end

    // R8 transparent staging while strobe held high
    send_frame(3'd3, 2'd1, 9'd300);
    ser_ld = 1'b1;
    tick();
    send_frame(3'd5, 2'd2, 9'd140);
    chk(m_div == 9'(pm), "R6", int'(m_div), pm);
    ser_ld = 1'b0;
    tick();
    chk_active("R8", 5, 2, 140);

    // R10 strobes ignored in parallel mode
    par_ld_n = 1'b0; par_m = 9'd222; par_n = 2'd3;
    tick();
    chk(t_sel == 3'd0, "R2", int'(t_sel), 0);
    send_frame(3'd6, 2'd0, 9'd333);
    chk(ser_dout == 1'b1, "R4", int'(ser_dout), 1);
    ser_ld = 1'b1;
    tick();
    ser_ld = 1'b0;
    tick();
    chk(m_div == 9'd222, "R10", int'(m_div), 222);
    par_ld_n = 1'b1;
    tick();
    chk_active("R10", 5, 3, 222);

    // R11 serial commit replaces pin values
    ser_ld = 1'b1;
    tick();
    ser_ld = 1'b0;
    tick();
    chk_active("R11", 6, 0, 333);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule